// File: doc/BRIEF.md
# Stereo Time-Shared FIR Filter

This block filters a stereo audio stream with a finite impulse response of up to 127 taps, typically to smooth or band-limit samples on their way to a DAC or an upsampler. The left and right channels use the same coefficient set. One dual-port memory holds that set and a circular history for each channel. A single multiply-accumulate unit works through the left taps and then the right taps, one tap per clock. With 127 taps a full stereo result takes a little under 256 clocks, so input samples must arrive slower than one per 256 clocks.

An input pair is offered with a one-cycle strobe. A strobe that arrives while the filter is busy is dropped and raises a sticky overrun flag. Coefficients are written one at a time through a load port while the filter is idle. The outputs are rounded, saturated 16-bit values, presented together with a one-cycle valid pulse.

Top module: `stereo_fir`

## Requirements
- R1: While reset is high and afterwards: out_valid, overrun, out_left and out_right are 0. After reset is released the filter spends 2^HW clocks (128 by default) writing zero to both sample histories. During that time it accepts no samples, so results after reset treat all earlier samples as zero.
- R2: A coefficient is written when coef_we is high while the filter is idle, to tap index coef_idx (0 to TAPS-1, where tap 0 multiplies the newest sample). Coefficients are kept through reset.
- R3: Each channel's output n is the sum over k = 0..TAPS-1 of c[k] * x[n-k], computed from signed 16-bit samples and signed 16-bit coefficients in a 40-bit accumulator. Both channels use the same c[k].
- R4: The sum is scaled by adding 2^14 and then shifting arithmetically right by 15. A tie therefore rounds toward positive infinity.
- R5: The scaled value is clamped to the range -32768 to 32767.
- R6: out_valid is high for exactly one cycle, on the 2*TAPS+1-th rising edge after the edge that accepted the input strobe. out_left and out_right change only in that cycle.
- R7: An in_valid strobe seen while the filter is not idle (clearing or computing) is ignored and sets overrun. overrun stays set until reset.
- R8: A coefficient write made while the filter is not idle, or in the same cycle as an accepted input strobe, is ignored.
- R9: After a reset, loading coefficients with |c| <= 16383 and then feeding a left impulse of +32767 and a right impulse of -32767 followed by zeros gives out_left = c[0], c[1], ... and out_right = -c[0], -c[1], ..., followed by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe offering a stereo input pair |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | 7 | Tap index of the coefficient being written |
| coef_data | input | 16 | Coefficient value, signed, scaled by 2^15 |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |
| out_left | output | 16 | Filtered left sample, signed |
| out_right | output | 16 | Filtered right sample, signed |
| overrun | output | 1 | Sticky flag: a strobe was dropped |

## Verification
The assertions assume that reset is held for at least one clock and that in_valid is a clean synchronous level. Under that assumption, every strobe that arrives while the filter is busy must show up as a set overrun flag, and every output pulse must come exactly 2*TAPS+2 sampled cycles after the strobe that was accepted. The directed stimulus drives all inputs on falling edges. It offers a new pair only after the previous out_valid pulse has been seen. It breaks that spacing on purpose, once during the post-reset clear and once in the middle of a computation, to exercise the drop and overrun path.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int SMP_W = 16;
    localparam int ACC_W = 40;
    localparam int FRAC  = 15;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_LEFT,
        ST_RIGHT,
        ST_DRAIN
    } seq_e;

    // Tag travelling with each memory read so the MAC knows its place in the pass
    typedef struct packed {
        logic vld;
        logic first;
        logic last;
        logic right;
    } tap_tag_t;

    localparam acc_t SAT_HI = acc_t'((1 << (SMP_W - 1)) - 1);
    localparam acc_t SAT_LO = acc_t'(-(1 << (SMP_W - 1)));
    localparam acc_t HALF   = acc_t'(1 << (FRAC - 1));

    function automatic smp_t round_sat(acc_t a);
        acc_t t;
        t = (a + HALF) >>> FRAC;
        if (t > SAT_HI)      return SAT_HI[SMP_W-1:0];
        else if (t < SAT_LO) return SAT_LO[SMP_W-1:0];
        else                 return t[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/fir_dpram.sv
module fir_dpram #(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wd,
    output logic [DW-1:0] a_rd,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wd,
    output logic [DW-1:0] b_rd
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wd;
        if (b_we) mem[b_addr] <= b_wd;
        a_rd <= mem[a_addr];
        b_rd <= mem[b_addr];
    end
endmodule

// File: rtl/fir_seq.sv
module fir_seq
    import fir_pkg::*;
#(
    parameter int TAPS = 127,
    parameter int HW   = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [SMP_W-1:0] in_left,
    input  logic [SMP_W-1:0] in_right,
    input  logic            coef_we,
    input  logic [HW-1:0]   coef_idx,
    input  logic [SMP_W-1:0] coef_data,
    output logic            a_we,
    output logic [HW+1:0]   a_addr,
    output logic [SMP_W-1:0] a_wd,
    output logic            b_we,
    output logic [HW+1:0]   b_addr,
    output logic [SMP_W-1:0] b_wd,
    output tap_tag_t        tag,
    output logic            idle,
    output logic            overrun
);
    localparam logic [1:0]    RG_COEF  = 2'd0;
    localparam logic [1:0]    RG_LEFT  = 2'd1;
    localparam logic [1:0]    RG_RIGHT = 2'd2;
    localparam logic [HW-1:0] LAST_TAP = HW'(TAPS - 1);
    localparam logic [HW-1:0] LAST_ROW = '1;

    seq_e          st;
    logic [HW-1:0] cnt;
    logic [HW-1:0] wptr;
    logic [HW-1:0] base;

    assign idle = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_CLEAR;
            cnt     <= '0;
            wptr    <= '0;
            base    <= '0;
            overrun <= 1'b0;
        end else begin
            if (in_valid && st != ST_IDLE) overrun <= 1'b1;
            case (st)
                ST_CLEAR: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_ROW) st <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (in_valid) begin
                        base <= wptr;
                        wptr <= wptr + 1'b1;
                        cnt  <= '0;
                        st   <= ST_LEFT;
                    end
                end
                ST_LEFT: begin
                    if (cnt == LAST_TAP) begin
                        cnt <= '0;
                        st  <= ST_RIGHT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RIGHT: begin
                    if (cnt == LAST_TAP) begin
                        cnt <= '0;
                        st  <= ST_DRAIN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRAIN: st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        a_we   = 1'b0;
        a_addr = {RG_COEF, cnt};
        a_wd   = '0;
        b_we   = 1'b0;
        b_addr = {RG_LEFT, base - cnt};
        b_wd   = '0;
        tag    = '0;
        case (st)
            ST_CLEAR: begin
                a_we   = 1'b1;
                a_addr = {RG_LEFT, cnt};
                b_we   = 1'b1;
                b_addr = {RG_RIGHT, cnt};
            end
            ST_IDLE: begin
                if (in_valid) begin
                    a_we   = 1'b1;
                    a_addr = {RG_LEFT, wptr};
                    a_wd   = in_left;
                    b_we   = 1'b1;
                    b_addr = {RG_RIGHT, wptr};
                    b_wd   = in_right;
                end else if (coef_we) begin
                    a_we   = 1'b1;
                    a_addr = {RG_COEF, coef_idx};
                    a_wd   = coef_data;
                end
            end
            ST_LEFT, ST_RIGHT: begin
                tag.vld   = 1'b1;
                tag.first = (cnt == '0);
                tag.last  = (cnt == LAST_TAP);
                tag.right = (st == ST_RIGHT);
                b_addr    = {(st == ST_RIGHT) ? RG_RIGHT : RG_LEFT, base - cnt};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fir_mac.sv
module fir_mac
    import fir_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  tap_tag_t        tag_in,
    input  logic [SMP_W-1:0] coef_rd,
    input  logic [SMP_W-1:0] smp_rd,
    output logic            out_valid,
    output smp_t            out_left,
    output smp_t            out_right
);
    tap_tag_t                  tag_q;
    acc_t                      acc;
    acc_t                      acc_next;
    smp_t                      hold_l;
    logic signed [2*SMP_W-1:0] prod;

    always_comb begin
        prod     = $signed(coef_rd) * $signed(smp_rd);
        acc_next = (tag_q.first ? acc_t'(0) : acc) + acc_t'(prod);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q     <= '0;
            acc       <= '0;
            hold_l    <= '0;
            out_left  <= '0;
            out_right <= '0;
            out_valid <= 1'b0;
        end else begin
            tag_q     <= tag_in;
            out_valid <= 1'b0;
            if (tag_q.vld) begin
                acc <= acc_next;
                if (tag_q.last) begin
                    if (!tag_q.right) begin
                        hold_l <= round_sat(acc_next);
                    end else begin
                        out_left  <= hold_l;
                        out_right <= round_sat(acc_next);
                        out_valid <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/stereo_fir.sv
module stereo_fir
    import fir_pkg::*;
#(
    parameter int TAPS = 127,
    localparam int HW  = $clog2(TAPS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [15:0]   in_left,
    input  logic [15:0]   in_right,
    input  logic          coef_we,
    input  logic [HW-1:0] coef_idx,
    input  logic [15:0]   coef_data,
    output logic          out_valid,
    output logic [15:0]   out_left,
    output logic [15:0]   out_right,
    output logic          overrun
);
    localparam int AW = HW + 2;

    logic            a_we, b_we;
    logic [AW-1:0]   a_addr, b_addr;
    logic [SMP_W-1:0] a_wd, b_wd, a_rd, b_rd;
    tap_tag_t        tag;
    logic            seq_idle;
    smp_t            res_l, res_r;

    fir_seq #(.TAPS(TAPS), .HW(HW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .coef_we   (coef_we),
        .coef_idx  (coef_idx),
        .coef_data (coef_data),
        .a_we      (a_we),
        .a_addr    (a_addr),
        .a_wd      (a_wd),
        .b_we      (b_we),
        .b_addr    (b_addr),
        .b_wd      (b_wd),
        .tag       (tag),
        .idle      (seq_idle),
        .overrun   (overrun)
    );

    fir_dpram #(.DW(SMP_W), .AW(AW)) u_mem (
        .clk    (clk),
        .a_we   (a_we),
        .a_addr (a_addr),
        .a_wd   (a_wd),
        .a_rd   (a_rd),
        .b_we   (b_we),
        .b_addr (b_addr),
        .b_wd   (b_wd),
        .b_rd   (b_rd)
    );

    fir_mac u_mac (
        .clk       (clk),
        .rst       (rst),
        .tag_in    (tag),
        .coef_rd   (a_rd),
        .smp_rd    (b_rd),
        .out_valid (out_valid),
        .out_left  (res_l),
        .out_right (res_r)
    );

    assign out_left  = res_l;
    assign out_right = res_r;
endmodule

// File: rtl/stereo_fir_chk.sv
module stereo_fir_chk #(
    parameter int TAPS = 127
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        idle,
    input logic        out_valid,
    input logic [15:0] out_left,
    input logic [15:0] out_right,
    input logic        overrun
);
    localparam int LAT = 2 * TAPS + 2;

    logic [15:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)                    lat_cnt <= '0;
        else if (in_valid && idle)  lat_cnt <= 16'd1;
        else if (out_valid)         lat_cnt <= '0;
        else if (lat_cnt != '0)     lat_cnt <= lat_cnt + 16'd1;
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid); // R6
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) out_valid |-> lat_cnt == 16'(LAT)); // R6
    AST_LEFT_HELD: assert property (@(posedge clk) disable iff (rst) !$stable(out_left) |-> out_valid); // R6
    AST_RIGHT_HELD: assert property (@(posedge clk) disable iff (rst) !$stable(out_right) |-> out_valid); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst) overrun |=> overrun); // R7
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst) (in_valid && !idle) |=> overrun); // R7
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(overrun) |-> $past(in_valid && !idle)); // R7
endmodule

bind stereo_fir stereo_fir_chk #(.TAPS(TAPS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .idle      (seq_idle),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .overrun   (overrun)
);

// File: tb/tb_stereo_fir.sv
module tb_stereo_fir;
    localparam int TAPS = 127;
    localparam int LAT  = 2 * TAPS + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_left = '0, in_right = '0;
    logic        coef_we = 1'b0;
    logic [6:0]  coef_idx = '0;
    logic [15:0] coef_data = '0;
    logic        out_valid, overrun;
    logic [15:0] out_left, out_right;

    always #10 clk = ~clk;

    stereo_fir #(.TAPS(TAPS)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right), .overrun(overrun)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, ns = 0;
    bit done = 0;
    int cm [TAPS];
    int hl [1024];
    int hr [1024];

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model(bit right);
        longint s = 0;
        for (int k = 0; k < TAPS; k++)
            if (ns - 1 - k >= 0)
                s += longint'(cm[k]) * longint'(right ? hr[ns-1-k] : hl[ns-1-k]);
        s = (s + 16384) >>> 15;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL R6 watchdog: actual %0d cycles expected below %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ns = 0;
    endtask

    task automatic wait_clear();
        repeat (140) @(negedge clk);
    endtask

    task automatic load_coef(int k, int v);
        @(negedge clk);
        coef_we = 1'b1; coef_idx = 7'(k); coef_data = 16'(v);
        @(negedge clk);
        coef_we = 1'b0;
        cm[k] = v;
    endtask

    // Offers one pair, waits for the result and checks timing and value
    task automatic send(int l, int r, string req, bit inject, output int ol, output int orr);
        int cnt, el, er;
        @(negedge clk);
        in_valid = 1'b1; in_left = 16'(l); in_right = 16'(r);
        hl[ns] = l; hr[ns] = r; ns++;
        el = model(0); er = model(1);
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 1;
        while (!out_valid && cnt < LAT + 20) begin
            if (inject && cnt == 50) begin in_valid = 1'b1; in_left = 16'h1357; in_right = 16'h2468; end
            else in_valid = 1'b0;
            if (inject && cnt == 60) begin coef_we = 1'b1; coef_idx = '0; coef_data = 16'h0BAD; end
            else coef_we = 1'b0;
            @(negedge clk);
            cnt++;
        end
        in_valid = 1'b0; coef_we = 1'b0;
        check(cnt == LAT, "R6", "cycles to out_valid", cnt, LAT);
        ol  = int'($signed(out_left));
        orr = int'($signed(out_right));
        check(ol == el, req, "out_left", ol, el);
        check(orr == er, req, "out_right", orr, er);
        @(negedge clk);
        check(!out_valid, "R6", "out_valid width", int'(out_valid), 0);
        check(int'($signed(out_left)) == ol, "R6", "out_left held", int'($signed(out_left)), ol);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(overrun == 1'b0, "R1", "overrun in reset", int'(overrun), 0);
        check(out_left == '0 && out_right == '0, "R1", "outputs in reset", int'(out_left), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        in_valid = 1'b1; in_left = 16'h7777; in_right = 16'h7777;
        @(negedge clk) in_valid = 1'b0;
        @(negedge clk);
        check(overrun == 1'b1, "R7", "strobe during clear sets overrun", int'(overrun), 1);
        wait_clear();
        check(out_valid == 1'b0, "R1", "strobe during clear gave no output", int'(out_valid), 0);
        do_reset();
        @(negedge clk);
        check(overrun == 1'b0, "R1", "overrun cleared by reset", int'(overrun), 0);
        wait_clear();
    endtask

    task automatic t_impulse();
        int ol, orr;
        for (int k = 0; k < TAPS; k++) load_coef(k, ((k * 2731 + 977) % 16001) - 8000);
        send(32767, -32767, "R3", 0, ol, orr);
        check(ol == cm[0], "R9", "impulse left tap 0", ol, cm[0]);
        check(orr == -cm[0], "R9", "impulse right tap 0", orr, -cm[0]);
        for (int k = 1; k < TAPS; k++) begin
            send(0, 0, "R3", 0, ol, orr);
            check(ol == cm[k], "R9", "impulse left tap", ol, cm[k]);
            check(orr == -cm[k], "R9", "impulse right tap", orr, -cm[k]);
        end
        send(0, 0, "R3", 0, ol, orr);
        check(ol == 0 && orr == 0, "R9", "impulse tail", ol, 0);
    endtask

    task automatic t_mixed();
        int ol, orr;
        logic [31:0] seed = 32'h1234_5678;
        for (int i = 0; i < 30; i++) begin
            int a, b;
            seed = seed * 32'd1103515245 + 32'd12345; a = int'($signed(seed[30:15]));
            seed = seed * 32'd1103515245 + 32'd12345; b = int'($signed(seed[30:15]));
            send(a, b, (i > 5) ? "R8" : "R3", i == 5, ol, orr);
            if (i >= 5) check(overrun == 1'b1, "R7", "overrun sticky after drop", int'(overrun), 1);
        end
    endtask

    task automatic t_retain();
        int ol, orr;
        do_reset();
        @(negedge clk);
        check(overrun == 1'b0, "R7", "overrun cleared only by reset", int'(overrun), 0);
        wait_clear();
        send(32767, -32767, "R2", 0, ol, orr);
        check(ol == cm[0], "R2", "coefficient 0 kept through reset", ol, cm[0]);
        send(0, 0, "R1", 0, ol, orr);
        check(ol == cm[1], "R1", "history cleared, tap 1 only", ol, cm[1]);
        send(0, 0, "R1", 0, ol, orr);
    endtask

    task automatic t_saturate();
        int ol, orr;
        for (int k = 0; k < TAPS; k++) load_coef(k, 20000);
        for (int i = 0; i < 3; i++) send(32767, 32767, "R5", 0, ol, orr);
        check(ol == 32767, "R5", "positive clamp left", ol, 32767);
        check(orr == 32767, "R5", "positive clamp right", orr, 32767);
        for (int i = 0; i < 6; i++) send(-32768, -32768, "R5", 0, ol, orr);
        check(ol == -32768, "R5", "negative clamp left", ol, -32768);
        check(orr == -32768, "R5", "negative clamp right", orr, -32768);
    endtask

    task automatic t_round();
        int ol, orr;
        load_coef(0, 1);
        for (int k = 1; k < TAPS; k++) load_coef(k, 0);
        send(16384, -16385, "R4", 0, ol, orr);
        check(ol == 1, "R4", "tie rounds up", ol, 1);
        check(orr == -1, "R4", "just below -half", orr, -1);
        send(16383, -16384, "R4", 0, ol, orr);
        check(ol == 0, "R4", "below half", ol, 0);
        check(orr == 0, "R4", "negative tie rounds up", orr, 0);
    endtask

    initial begin
        t_reset_state();
        t_impulse();
        t_mixed();
        t_retain();
        t_saturate();
        t_round();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule